// File: doc/BRIEF.md
# Add/Subtract Condition Flag Generator

This block produces the four condition flags (negative, zero, carry, overflow) for add, add-with-carry, subtract, subtract-with-carry and logical operations. The caller supplies both operands, the result its own adder or logic unit produced, the incoming carry and, for logical operations, the shifter carry-out. The block does not rebuild an adder carry chain. It takes carry and overflow from unsigned comparisons and sign tests between the operands and the result.

A small decision stage sets the flag write enable. When an explicit set-flags request is present, the request decides. When no request is present, flags are written only outside a conditional-execution block. The block holds the flag state in a register that loads the next NZCV value when the write enable is high.

Top module: `nzcv_flag_unit`

## Requirements
- R1: For every valid operation code (0 to 4), `flags_d[3]` (N) equals the most significant bit of `res`, and `flags_d[2]` (Z) is 1 exactly when `res` is zero. The flag vector is packed as {N,Z,C,V} from bit 3 down to bit 0.
- R2: For op code 0 (add), `flags_d[1]` (C) is 1 exactly when `res` is unsigned-less-than `opa`.
- R3: For op code 1 (add with carry), C is 1 when `res` is unsigned-less-than `opa`, or when `res` equals `opa` and `carry_in` is 1.
- R4: For op code 2 (subtract), C is 1 exactly when `opa` is unsigned-greater-or-equal to `opb`.
- R5: For op code 3 (subtract with carry), C is 1 when `opa` is unsigned-greater than `opb`, or when the two are equal and `carry_in` is 1.
- R6: For op codes 0 and 1, `flags_d[0]` (V) is the top bit of (res^opa)&~(opa^opb). For op codes 2 and 3, V is the top bit of (res^opa)&(opa^opb).
- R7: For op code 4 (logical), C equals `shift_carry` and V equals the stored V flag `flags_q[0]`.
- R8: For op codes 5, 6 and 7, `flag_we` is 0, `flags_d` equals `flags_q`, and the stored flags do not change.
- R9: For a valid op code, `flag_we` equals `sf_value` when `sf_valid` is 1. When `sf_valid` is 0, `flag_we` is the inverse of `in_cond_blk`.
- R10: On a rising clock edge `flags_q` loads `flags_d` when `flag_we` is 1 and holds otherwise. A synchronous `rst` clears `flags_q` to 0 and takes priority over a load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_sel | input | 3 | Operation code (0 add, 1 add with carry, 2 subtract, 3 subtract with carry, 4 logical) |
| opa | input | WIDTH | First operand |
| opb | input | WIDTH | Second operand |
| res | input | WIDTH | Result of the operation |
| carry_in | input | 1 | Incoming carry flag |
| shift_carry | input | 1 | Shifter carry-out for logical operations |
| sf_valid | input | 1 | An explicit set-flags indication is present |
| sf_value | input | 1 | Value of the explicit set-flags indication |
| in_cond_blk | input | 1 | The operation is inside a conditional-execution block |
| flags_d | output | 4 | Next {N,Z,C,V} |
| flag_we | output | 1 | Flag write enable |
| flags_q | output | 4 | Stored {N,Z,C,V} |

## Verification
The only internal state is the stored flag vector. If that state is wrong, it appears at `flags_q` one edge after the faulty load or hold. It also appears on the same cycle at `flags_d[0]` during any logical operation, and on all of `flags_d` during an unused operation code, because both of those paths pass the stored flags through. The bench checks against an arithmetic reference at a 4-bit width. It sweeps every operand pair and every carry value for each operation, and it compares both the combinational flags and the registered flags after each edge. This exposes a wrong comparison or a corrupted register within one cycle.

// File: rtl/nzcv_pkg.sv
package nzcv_pkg;
    typedef enum logic [2:0] {
        OP_ADD   = 3'd0,
        OP_ADC   = 3'd1,
        OP_SUB   = 3'd2,
        OP_SBC   = 3'd3,
        OP_LOGIC = 3'd4
    } flag_op_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } nzcv_t;

    typedef struct packed {
        nzcv_t flags;
    } flag_state_t;
endpackage

// File: rtl/nzcv_arith.sv
module nzcv_arith
    import nzcv_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  flag_op_e          op,
    input  logic [WIDTH-1:0]  opa,
    input  logic [WIDTH-1:0]  opb,
    input  logic [WIDTH-1:0]  res,
    input  logic              carry_in,
    input  logic              shift_carry,
    input  logic              v_hold,
    output nzcv_t             flags,
    output logic              op_known
);
    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] add_v_vec;
    logic [WIDTH-1:0] sub_v_vec;
    logic             res_lt_a;
    logic             res_eq_a;
    logic             a_gt_b;
    logic             a_eq_b;

    always_comb begin
        add_v_vec = (res ^ opa) & ~(opa ^ opb);
        sub_v_vec = (res ^ opa) & (opa ^ opb);
        res_lt_a  = res < opa;
        res_eq_a  = res == opa;
        a_gt_b    = opa > opb;
        a_eq_b    = opa == opb;

        flags.n   = res[MSB];
        flags.z   = (res == '0);
        flags.c   = 1'b0;
        flags.v   = 1'b0;
        op_known  = 1'b1;
        unique case (op)
            OP_ADD: begin
                flags.c = res_lt_a;
                flags.v = add_v_vec[MSB];
            end
            OP_ADC: begin
                flags.c = res_lt_a | (res_eq_a & carry_in);
                flags.v = add_v_vec[MSB];
            end
            OP_SUB: begin
                flags.c = a_gt_b | a_eq_b;
                flags.v = sub_v_vec[MSB];
            end
            OP_SBC: begin
                flags.c = a_gt_b | (a_eq_b & carry_in);
                flags.v = sub_v_vec[MSB];
            end
            OP_LOGIC: begin
                flags.c = shift_carry;
                flags.v = v_hold;
            end
            default: op_known = 1'b0;
        endcase
    end
endmodule

// File: rtl/nzcv_gate.sv
module nzcv_gate (
    input  logic op_known,
    input  logic sf_valid,
    input  logic sf_value,
    input  logic in_cond_blk,
    output logic write_en
);
    always_comb begin
        if (!op_known)
            write_en = 1'b0;
        else if (sf_valid)
            write_en = sf_value;
        else
            write_en = ~in_cond_blk;
    end
endmodule

// File: rtl/nzcv_flag_unit.sv
module nzcv_flag_unit
    import nzcv_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [2:0]       op_sel,
    input  logic [WIDTH-1:0] opa,
    input  logic [WIDTH-1:0] opb,
    input  logic [WIDTH-1:0] res,
    input  logic             carry_in,
    input  logic             shift_carry,
    input  logic             sf_valid,
    input  logic             sf_value,
    input  logic             in_cond_blk,
    output logic [3:0]       flags_d,
    output logic             flag_we,
    output logic [3:0]       flags_q
);
    flag_state_t st_d, st_q;
    nzcv_t       calc_flags;
    logic        op_known;
    logic        write_en;

    nzcv_arith #(.WIDTH(WIDTH)) u_arith (
        .op          (flag_op_e'(op_sel)),
        .opa         (opa),
        .opb         (opb),
        .res         (res),
        .carry_in    (carry_in),
        .shift_carry (shift_carry),
        .v_hold      (st_q.flags.v),
        .flags       (calc_flags),
        .op_known    (op_known)
    );

    nzcv_gate u_gate (
        .op_known    (op_known),
        .sf_valid    (sf_valid),
        .sf_value    (sf_value),
        .in_cond_blk (in_cond_blk),
        .write_en    (write_en)
    );

    always_comb begin
        st_d = st_q;
        if (write_en)
            st_d.flags = calc_flags;
        flags_d = op_known ? calc_flags : st_q.flags;
        flag_we = write_en;
        flags_q = st_q.flags;
    end

    always_ff @(posedge clk) begin
        if (rst)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    // R10: a load copies the announced next flags
    p_load_r10: assert property (@(posedge clk) disable iff (rst)
        flag_we |=> flags_q == $past(flags_d));
    // R10 / R8: no write enable, no change
    p_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !flag_we |=> $stable(flags_q));
    // R7: logical operations keep V
    p_logic_keeps_v_r7: assert property (@(posedge clk) disable iff (rst)
        (op_sel == 3'd4 && flag_we) |=> flags_q[0] == $past(flags_q[0]));
    // R4: equal operands never borrow
    p_sub_equal_carry_r4: assert property (@(posedge clk) disable iff (rst)
        (op_sel == 3'd2 && opa == opb) |-> flags_d[1]);
    // R9: explicit request decides
    p_explicit_req_r9: assert property (@(posedge clk) disable iff (rst)
        (op_sel <= 3'd4 && sf_valid) |-> flag_we == sf_value);
    // R8: unused codes never write
    p_unused_code_r8: assert property (@(posedge clk) disable iff (rst)
        (op_sel > 3'd4) |-> !flag_we && flags_d == flags_q);
endmodule

// File: tb/nzcv_flag_unit_tb.sv
module nzcv_flag_unit_tb;
    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [2:0]   op_sel = '0;
    logic [W-1:0] opa = '0, opb = '0, res = '0;
    logic         carry_in = 1'b0, shift_carry = 1'b0;
    logic         sf_valid = 1'b0, sf_value = 1'b0, in_cond_blk = 1'b0;
    logic [3:0]   flags_d, flags_q;
    logic         flag_we;

    int n_checks = 0;
    int n_fail   = 0;
    logic [3:0] model = '0;

    always #4 clk = ~clk;

    nzcv_flag_unit #(.WIDTH(W)) u_dut (
        .clk(clk), .rst(rst), .op_sel(op_sel), .opa(opa), .opb(opb), .res(res),
        .carry_in(carry_in), .shift_carry(shift_carry), .sf_valid(sf_valid),
        .sf_value(sf_value), .in_cond_blk(in_cond_blk),
        .flags_d(flags_d), .flag_we(flag_we), .flags_q(flags_q)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h (op %0d a %0d b %0d r %0d)",
                     req, act, exp, op_sel, opa, opb, res);
        end
    endtask

    // returns {res, N, Z, C, V} computed from a wide sum
    function automatic logic [7:0] ref_calc(input int op, input int a, input int b,
                                            input logic ci, input logic sc, input logic vh);
        logic [4:0] sum;
        logic [3:0] bb, r;
        logic       cc, c, v;
        if (op == 4) begin
            r = 4'(a ^ b);
            return {r, r[3], r == 4'd0, sc, vh};
        end
        bb  = (op >= 2) ? ~4'(b) : 4'(b);
        cc  = (op == 0) ? 1'b0 : (op == 2) ? 1'b1 : ci;
        sum = 5'(a) + 5'(bb) + 5'(cc);
        r   = sum[3:0];
        c   = sum[4];
        v   = (4'(a) >> 3 == bb >> 3) && (r[3] != 4'(a) >> 3);
        return {r, r[3], r == 4'd0, c, v};
    endfunction

    function automatic string req_of(input int op);
        case (op)
            0: return "R1,R2,R6";
            1: return "R1,R3,R6";
            2: return "R1,R4,R6";
            3: return "R1,R5,R6";
            default: return "R1,R7";
        endcase
    endfunction

    // one vector: drive at negedge, check comb, check register after edge
    task automatic step(input int op, input int a, input int b, input logic ci, input logic sc,
                        input logic sv, input logic sval, input logic icb, input logic chk_flags);
        logic [7:0] e;
        logic       we_exp;
        @(negedge clk);
        e = ref_calc(op, a, b, ci, sc, model[0]);
        op_sel = 3'(op); opa = 4'(a); opb = 4'(b); res = e[7:4];
        carry_in = ci; shift_carry = sc;
        sf_valid = sv; sf_value = sval; in_cond_blk = icb;
        we_exp = sv ? sval : ~icb;
        #1;
        if (chk_flags) chk(req_of(op), {4'd0, flags_d}, {4'd0, e[3:0]});
        chk("R9", {7'd0, flag_we}, {7'd0, we_exp});
        @(posedge clk);
        if (we_exp) model = e[3:0];
        #1;
        chk("R10", {4'd0, flags_q}, {4'd0, model});
    endtask

    initial begin
        fork
            begin
                repeat (3) @(posedge clk);
                #1;
                chk("R10 reset", {4'd0, flags_q}, 8'd0);
                @(negedge clk);
                rst = 1'b0;

                // exhaustive sweep of every op, operand pair, carry
                for (int op = 0; op <= 4; op++)
                    for (int a = 0; a < 16; a++)
                        for (int b = 0; b < 16; b++)
                            for (int ci = 0; ci < 2; ci++)
                                step(op, a, b, ci[0], a[0] ^ ci[0], 1'b0, 1'b0, 1'b0, 1'b1);

                // write-enable decision, alternating vectors so holds are visible
                for (int g = 0; g < 8; g++) begin
                    step(0, 3, 5, 1'b0, 1'b0, g[2], g[1], g[0], 1'b1);
                    step(0, 0, 0, 1'b0, 1'b0, g[2], g[1], g[0], 1'b1);
                end

                // unused op codes: no write, next equals stored
                step(0, 3, 5, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
                for (int op = 5; op < 8; op++) begin
                    @(negedge clk);
                    op_sel = 3'(op); opa = 4'd0; opb = 4'd0; res = 4'd0;
                    sf_valid = 1'b1; sf_value = 1'b1; in_cond_blk = 1'b0;
                    #1;
                    chk("R8 we", {7'd0, flag_we}, 8'd0);
                    chk("R8 next", {4'd0, flags_d}, {4'd0, model});
                    @(posedge clk); #1;
                    chk("R8 stored", {4'd0, flags_q}, {4'd0, model});
                end

                // reset wins over a load
                @(negedge clk);
                op_sel = 3'd0; opa = 4'd0; opb = 4'd0; res = 4'd0;
                sf_valid = 1'b0; in_cond_blk = 1'b0; rst = 1'b1;
                @(posedge clk); #1;
                chk("R10 reset priority", {4'd0, flags_q}, 8'd0);
            end
            begin
                repeat (100000) @(posedge clk);
                n_checks++; n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule